// File: doc/BRIEF.md
# Floating-Point Add/Subtract Butterfly Pair

This unit takes two floating-point operands, A and B, and in one issue forms both their sum A + B and the reversed difference B - A. A mode input decides which of the two results is placed on the primary output; the other goes to the secondary output. This lets an FFT or DCT butterfly stage get both halves of a radix-2 add/subtract from a single issue, in whichever order the surrounding datapath wants them.

A precision input selects binary64, or binary32 carried in the low 32-bit lane. Rounding is always round-to-nearest, ties-to-even. Subnormal operands are read as zero and subnormal results are flushed to zero. Infinities, NaNs and signed zeros follow the special-value rules below. One exception-flag vector covers both computations, and a class code describes the primary result. Each accepted operand pair gives exactly one result pair one clock later.

Top module: `bfly_addsub_pair`

## Requirements
- R1: With `in_sub`=0, `out_pri` is A + B and `out_sec` is B - A.
- R2: With `in_sub`=1, `out_pri` is B - A and `out_sec` is A + B.
- R3: The difference is always B minus A and never A minus B: A=2.0, B=1.0 gives a difference of -1.0.
- R4: Results are rounded to nearest, with ties going to the even significand. A rounded result sets the inexact flag, `out_flags[0]`.
- R5: `in_dbl`=1 treats the operands and results as binary64. `in_dbl`=0 treats them as binary32 in bits [31:0].
- R6: In binary32 mode, operand bits [63:32] are ignored and both results have bits [63:32] equal to zero.
- R7: When an addition effectively combines infinities of opposite sign, that result is the default quiet NaN and the inf-minus-inf flag `out_flags[3]` is set. So opposite-sign infinities poison the sum, and same-sign infinities poison the difference. The default quiet NaN is 0x7FF8000000000000 in binary64 and 0x7FC00000 in binary32.
- R8: Any NaN operand makes both results the default quiet NaN. A signalling NaN operand (quiet bit, the top fraction bit, equal to zero) sets `out_flags[4]`; a quiet NaN operand sets no flag.
- R9: An exact zero from operands of opposite effective sign is +0. Adding two zeros of the same sign keeps that sign.
- R10: A rounded exponent above the format maximum gives a correctly signed infinity and sets overflow `out_flags[2]` and inexact `out_flags[0]`.
- R11: A nonzero result below the smallest normal magnitude becomes a zero of the result's sign and sets underflow `out_flags[1]` and inexact `out_flags[0]`. A subnormal operand is read as a zero of its sign and raises no flag.
- R12: `out_flags` is the OR of the flags of both computations. `out_cls` gives the class of `out_pri`: 0 +normal, 1 -normal, 2 +zero, 3 -zero, 4 +infinity, 5 -infinity, 6 quiet NaN.
- R13: After reset `out_valid` is 0. Every cycle with `in_valid`=1 gives exactly one `out_valid`=1 on the next cycle, including back-to-back issues. Results hold when there is no issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair valid |
| in_sub | input | 1 | 0: primary is sum; 1: primary is B - A |
| in_dbl | input | 1 | 1: binary64; 0: binary32 in low lane |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| out_valid | output | 1 | Result pair valid |
| out_pri | output | 64 | Primary result |
| out_sec | output | 64 | Secondary result |
| out_flags | output | 5 | {snan-invalid, inf-inf invalid, overflow, underflow, inexact} |
| out_cls | output | 3 | Class code of the primary result |

## Verification
Plain integer-valued pairs are applied in both modes and in both operand orders. Together they separate a correct output swap from a swapped difference (B - A against A - B). Halfway cases, one that must round down to even and one that must round up, are tried at both precisions, so a rounding position that is off by one bit or a truncating rounder is exposed. Opposite-sign and same-sign infinity pairs, signalling and quiet NaNs, cancelling and same-sign zeros, overflow at maximum magnitude, a cancellation that falls below the normal range, and a subnormal operand each check one special-value path in one lane. A pair in which only one lane raises a flag shows whether the flags are merged across lanes.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int WORD_W  = 64;
  localparam int EXP_W   = 11;
  localparam int MAN_W   = 53;
  localparam int GRS_W   = 3;
  localparam int SUM_W   = MAN_W + GRS_W;        // 56-bit aligned field
  localparam int SGL_CUT = 29;                    // significand bits dropped in binary32
  localparam int NUM_LANES = 2;

  localparam logic [WORD_W-1:0] QNAN_D = 64'h7FF8_0000_0000_0000;
  localparam logic [WORD_W-1:0] QNAN_S = 64'h0000_0000_7FC0_0000;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
    logic             zero;
    logic             inf;
    logic             nan;
    logic             snan;
  } fp_unp_t;

  typedef struct packed {
    logic inv_snan;
    logic inv_isi;
    logic ovf;
    logic ufl;
    logic inx;
  } fp_flags_t;

  typedef enum logic [2:0] {
    CLS_POS_NORM = 3'd0,
    CLS_NEG_NORM = 3'd1,
    CLS_POS_ZERO = 3'd2,
    CLS_NEG_ZERO = 3'd3,
    CLS_POS_INF  = 3'd4,
    CLS_NEG_INF  = 3'd5,
    CLS_QNAN     = 3'd6
  } fp_cls_t;
endpackage

// File: rtl/bfly_unpack.sv
module bfly_unpack
  import bfly_pkg::*;
(
  input  logic [WORD_W-1:0] raw,
  input  logic              dbl,
  output fp_unp_t           unp
);
  // binary32 exponents are rebased onto the binary64 bias (1023 - 127)
  localparam logic [EXP_W-1:0] REBIAS = 11'd896;

  always_comb begin
    unp = '0;
    if (dbl) begin
      unp.sign = raw[63];
      if (raw[62:52] == '0) begin
        unp.zero = 1'b1;                       // subnormal read as zero (R11)
      end else if (raw[62:52] == '1) begin
        unp.inf  = (raw[51:0] == '0);
        unp.nan  = (raw[51:0] != '0);
        unp.snan = (raw[51:0] != '0) && !raw[51];
      end else begin
        unp.exp = raw[62:52];
        unp.man = {1'b1, raw[51:0]};
      end
    end else begin
      unp.sign = raw[31];
      if (raw[30:23] == '0) begin
        unp.zero = 1'b1;
      end else if (raw[30:23] == '1) begin
        unp.inf  = (raw[22:0] == '0);
        unp.nan  = (raw[22:0] != '0);
        unp.snan = (raw[22:0] != '0) && !raw[22];
      end else begin
        unp.exp = {3'b000, raw[30:23]} + REBIAS;
        unp.man = {1'b1, raw[22:0], {SGL_CUT{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/bfly_fadd_core.sv
module bfly_fadd_core
  import bfly_pkg::*;
#(
  parameter bit NEG_A = 1'b0            // 1: lane computes B + (-A)
)(
  input  fp_unp_t           opa,
  input  fp_unp_t           opb,
  input  logic              dbl,
  output logic [WORD_W-1:0] res,
  output fp_flags_t         flg,
  output fp_cls_t           cls
);
  localparam int LZ_W = $clog2(SUM_W + 1);

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [SUM_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = '0;
    for (int i = 0; i < SUM_W; i++) begin
      if (v[i]) n = LZ_W'(SUM_W - 1 - i);
    end
    return n;
  endfunction

  logic                 sa, sb, sx, sy, a_big, eff_sub;
  logic [EXP_W-1:0]     ex, ey, dexp;
  logic [MAN_W-1:0]     mx, my;
  logic [SUM_W-1:0]     ext, shifted, yal, nrm;
  logic                 stk, guard, sticky, lsb;
  logic [SUM_W:0]       wide;
  logic [LZ_W-1:0]      lz;
  logic signed [12:0]   e_n, e_r, emax, emin;
  logic [MAN_W-1:0]     keep, frac;
  logic [MAN_W:0]       rnd;
  logic [7:0]           e_s;
  logic                 rs, is_nan, is_inf, is_zero;

  always_comb begin
    sa    = opa.sign ^ NEG_A;
    sb    = opb.sign;
    a_big = {opa.exp, opa.man} >= {opb.exp, opb.man};
    sx = a_big ? sa : sb;        sy = a_big ? sb : sa;
    ex = a_big ? opa.exp : opb.exp;  ey = a_big ? opb.exp : opa.exp;
    mx = a_big ? opa.man : opb.man;  my = a_big ? opb.man : opa.man;
    dexp = ex - ey;

    // align the smaller operand, folding lost bits into a sticky bit
    ext = {my, {GRS_W{1'b0}}};
    if (dexp >= EXP_W'(SUM_W)) begin
      shifted = '0;
      stk     = |ext;
    end else begin
      shifted = ext >> dexp[LZ_W-1:0];
      stk     = |(ext & ((SUM_W'(1) << dexp[LZ_W-1:0]) - SUM_W'(1)));
    end
    yal = {shifted[SUM_W-1:1], shifted[0] | stk};

    eff_sub = sx ^ sy;
    wide = eff_sub ? ({1'b0, mx, {GRS_W{1'b0}}} - {1'b0, yal})
                   : ({1'b0, mx, {GRS_W{1'b0}}} + {1'b0, yal});

    lz = lead_zeros(wide[SUM_W-1:0]);
    if (wide[SUM_W]) begin
      nrm = {wide[SUM_W:2], wide[1] | wide[0]};
      e_n = $signed({2'b00, ex}) + 13'sd1;
    end else begin
      nrm = wide[SUM_W-1:0] << lz;
      e_n = $signed({2'b00, ex}) - $signed({{(13-LZ_W){1'b0}}, lz});
    end

    // round to nearest even at the precision-dependent position (R4)
    keep = nrm[SUM_W-1:GRS_W];
    if (!dbl) keep[SGL_CUT-1:0] = '0;
    guard  = dbl ? nrm[2]  : nrm[SGL_CUT+2];
    sticky = dbl ? |nrm[1:0] : |nrm[SGL_CUT+1:0];
    lsb    = dbl ? nrm[3]  : nrm[SGL_CUT+3];
    rnd = {1'b0, keep} +
          ((guard & (sticky | lsb)) ? (dbl ? (MAN_W+1)'(1) : (MAN_W+1)'(1) << SGL_CUT)
                                    : (MAN_W+1)'(0));
    if (rnd[MAN_W]) begin
      frac = rnd[MAN_W:1];
      e_r  = e_n + 13'sd1;
    end else begin
      frac = rnd[MAN_W-1:0];
      e_r  = e_n;
    end
    emax = dbl ? 13'sd2046 : 13'sd1150;
    emin = dbl ? 13'sd1    : 13'sd897;
    e_s  = e_r[7:0] - 8'h80;             // rebias to binary32

    flg = '0; rs = sx; is_nan = 1'b0; is_inf = 1'b0; is_zero = 1'b0;
    if (opa.nan | opb.nan) begin
      is_nan = 1'b1;
      flg.inv_snan = opa.snan | opb.snan;                 // R8
    end else if (opa.inf & opb.inf & (sa != sb)) begin
      is_nan = 1'b1;
      flg.inv_isi = 1'b1;                                 // R7
    end else if (opa.inf | opb.inf) begin
      is_inf = 1'b1;
      rs = opa.inf ? sa : sb;
    end else if (opa.zero & opb.zero) begin
      is_zero = 1'b1;
      rs = sa & sb;                                       // R9
    end else if (wide == '0) begin
      is_zero = 1'b1;
      rs = 1'b0;                                          // R9 cancellation
    end else begin
      flg.inx = guard | sticky;
      if (e_r > emax) begin
        is_inf = 1'b1; flg.ovf = 1'b1; flg.inx = 1'b1;    // R10
      end else if (e_r < emin) begin
        is_zero = 1'b1; flg.ufl = 1'b1; flg.inx = 1'b1;   // R11
      end
    end

    if (is_nan)       res = dbl ? QNAN_D : QNAN_S;
    else if (is_inf)  res = dbl ? {rs, 11'h7FF, 52'b0} : {32'b0, rs, 8'hFF, 23'b0};
    else if (is_zero) res = dbl ? {rs, 63'b0} : {32'b0, rs, 31'b0};
    else              res = dbl ? {rs, e_r[10:0], frac[51:0]}
                                : {32'b0, rs, e_s, frac[51:SGL_CUT]};

    if (is_nan)       cls = CLS_QNAN;
    else if (is_inf)  cls = rs ? CLS_NEG_INF  : CLS_POS_INF;
    else if (is_zero) cls = rs ? CLS_NEG_ZERO : CLS_POS_ZERO;
    else              cls = rs ? CLS_NEG_NORM : CLS_POS_NORM;
  end
endmodule

// File: rtl/bfly_addsub_pair.sv
module bfly_addsub_pair
  import bfly_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sub,
  input  logic        in_dbl,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  output logic        out_valid,
  output logic [63:0] out_pri,
  output logic [63:0] out_sec,
  output logic [4:0]  out_flags,
  output logic [2:0]  out_cls
);
  // reset: asserted asynchronously, released through a synchronizer
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  fp_unp_t a_unp, b_unp;
  bfly_unpack u_unp_a (.raw(in_a), .dbl(in_dbl), .unp(a_unp));
  bfly_unpack u_unp_b (.raw(in_b), .dbl(in_dbl), .unp(b_unp));

  // lane 0: A + B, lane 1: B + (-A)
  logic [WORD_W-1:0] lane_res [NUM_LANES];
  fp_flags_t         lane_flg [NUM_LANES];
  fp_cls_t           lane_cls [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    bfly_fadd_core #(.NEG_A(g == 1)) u_core (
      .opa(a_unp), .opb(b_unp), .dbl(in_dbl),
      .res(lane_res[g]), .flg(lane_flg[g]), .cls(lane_cls[g])
    );
  end

  // next-state
  logic [WORD_W-1:0] pri_d, sec_d;
  fp_flags_t         flg_d;
  fp_cls_t           cls_d;

  always_comb begin
    pri_d = in_sub ? lane_res[1] : lane_res[0];
    sec_d = in_sub ? lane_res[0] : lane_res[1];
    cls_d = in_sub ? lane_cls[1] : lane_cls[0];
    flg_d = lane_flg[0] | lane_flg[1];
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_pri   <= pri_d;
      out_sec   <= sec_d;
      out_flags <= flg_d;
      out_cls   <= cls_d;
    end
  end

  // assertions
  AST_ISSUE_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);                                          // R13
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);                                        // R13
  AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !$past(in_dbl)) |-> (out_pri[63:32] == '0 && out_sec[63:32] == '0)); // R6
  AST_ISI_YIELDS_NAN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_flags[3]) |->
      (out_pri == QNAN_D || out_pri == QNAN_S || out_sec == QNAN_D || out_sec == QNAN_S)); // R7
  AST_NAN_CLASS_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_cls == CLS_QNAN) |-> (out_pri == QNAN_D || out_pri == QNAN_S)); // R12
  AST_OVF_IS_INEXACT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_flags[2]) |-> out_flags[0]);                    // R10
  AST_UFL_IS_INEXACT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_flags[1]) |-> out_flags[0]);                    // R11
endmodule

// File: tb/bfly_addsub_pair_tb.sv
`timescale 1ns/1ps
module bfly_addsub_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sub, in_dbl;
  logic [63:0] in_a, in_b;
  logic        out_valid;
  logic [63:0] out_pri, out_sec;
  logic [4:0]  out_flags;
  logic [2:0]  out_cls;

  always #2.5 clk = ~clk;   // 200 MHz

  bfly_addsub_pair dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub), .in_dbl(in_dbl),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_pri(out_pri),
    .out_sec(out_sec), .out_flags(out_flags), .out_cls(out_cls)
  );

  typedef struct {
    logic [63:0] pri;
    logic [63:0] sec;
    logic [4:0]  fl;
    logic [2:0]  cls;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   n_sent   = 0;
  int   n_seen   = 0;
  bit   done     = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: pushes the expected item, drives one issue cycle
  task automatic send(input bit sub, input bit dbl, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] pri, input logic [63:0] sec,
                      input logic [4:0] fl, input logic [2:0] cls, input string tag);
    exp_t e;
    e.pri = pri; e.sec = sec; e.fl = fl; e.cls = cls; e.tag = tag;
    exp_q.push_back(e);
    in_valid = 1'b1; in_sub = sub; in_dbl = dbl; in_a = a; in_b = b;
    n_sent++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_a = 64'hFFFF_FFFF_FFFF_FFFF; in_b = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops and compares on every result
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      n_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R13", "unexpected out_valid", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(out_pri == e.pri, e.tag, "out_pri", out_pri, e.pri);
        chk(out_sec == e.sec, e.tag, "out_sec", out_sec, e.sec);
        chk(out_flags == e.fl, {e.tag, "/R12"}, "out_flags", 64'(out_flags), 64'(e.fl));
        chk(out_cls == e.cls, {e.tag, "/R12"}, "out_cls", 64'(out_cls), 64'(e.cls));
      end
    end
  end

  localparam logic [63:0] D1 = 64'h3FF0_0000_0000_0000, D2 = 64'h4000_0000_0000_0000;
  localparam logic [63:0] D3 = 64'h4008_0000_0000_0000, DM1 = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000, NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QN = 64'h7FF8_0000_0000_0000, QS = 64'h0000_0000_7FC0_0000;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sub = 1'b0; in_dbl = 1'b1; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R13", "out_valid after reset", 64'(out_valid), 64'd0);

    // R1 / R2 back to back, R13
    send(0, 1, D1, D2, D3, D1, 5'h00, 3'd0, "R1");
    send(1, 1, D1, D2, D1, D3, 5'h00, 3'd0, "R2");
    idle(2);
    // R3: B - A, not A - B
    send(0, 1, D2, D1, D3, DM1, 5'h00, 3'd0, "R3");
    send(1, 1, D2, D1, DM1, D3, 5'h00, 3'd1, "R3_sub");
    idle(1);
    // R5 / R6: binary32 with junk upper input bits
    send(0, 0, 64'hDEAD_BEEF_3FC0_0000, 64'h1234_5678_3E80_0000,
         64'h0000_0000_3FE0_0000, 64'h0000_0000_BFA0_0000, 5'h00, 3'd0, "R5_R6");
    idle(3);
    // R7: infinities
    send(0, 1, PINF, NINF, QN, NINF, 5'h08, 3'd6, "R7_opp");
    send(1, 1, PINF, PINF, QN, PINF, 5'h08, 3'd6, "R7_same");
    send(0, 0, 64'h0000_0000_7F80_0000, 64'h0000_0000_FF80_0000,
         QS, 64'h0000_0000_FF80_0000, 5'h08, 3'd6, "R7_sgl");
    idle(1);
    // R8: NaNs
    send(0, 1, 64'h7FF0_0000_0000_0001, D1, QN, QN, 5'h10, 3'd6, "R8_snan");
    send(1, 1, D1, 64'h7FF8_0000_0000_0123, QN, QN, 5'h00, 3'd6, "R8_qnan");
    idle(2);
    // R9: signed zeros
    send(1, 1, D1, D1, 64'h0, D2, 5'h00, 3'd2, "R9_cancel");
    send(0, 1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
         64'h8000_0000_0000_0000, 64'h0, 5'h00, 3'd3, "R9_negzero");
    idle(1);
    // R10: overflow
    send(0, 1, 64'h7FEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF, PINF, 64'h0, 5'h05, 3'd4, "R10_dbl");
    send(0, 0, 64'h0000_0000_FF7F_FFFF, 64'h0000_0000_FF7F_FFFF,
         64'h0000_0000_FF80_0000, 64'h0, 5'h05, 3'd5, "R10_sgl");
    idle(2);
    // R11 / R12: difference flushes, flags merged from that lane only
    send(0, 1, 64'h0010_0000_0000_0000, 64'h0018_0000_0000_0000,
         64'h0024_0000_0000_0000, 64'h0, 5'h03, 3'd0, "R11_R12_flush");
    send(1, 1, 64'h0000_0000_0000_0001, D1, D1, D1, 5'h00, 3'd0, "R11_subnormal_in");
    idle(1);
    // R4: ties to even, both directions and both precisions
    send(0, 1, D1, 64'h3CA0_0000_0000_0000, D1, 64'hBFEF_FFFF_FFFF_FFFF, 5'h01, 3'd0, "R4_tie_down");
    send(0, 1, 64'h3FF0_0000_0000_0001, 64'h3CA0_0000_0000_0000,
         64'h3FF0_0000_0000_0002, DM1, 5'h01, 3'd0, "R4_tie_up");
    send(1, 0, 64'h0000_0000_3F80_0000, 64'h0000_0000_3380_0000,
         64'h0000_0000_BF7F_FFFF, 64'h0000_0000_3F80_0000, 5'h01, 3'd1, "R4_R5_sgl");
    idle(5);

    chk(exp_q.size() == 0, "R13", "results outstanding", 64'(exp_q.size()), 64'd0);
    chk(n_seen == n_sent, "R13", "result count", 64'(n_seen), 64'(n_sent));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule